// File: doc/BRIEF.md
# Tick-Paced Revolution and Sector Slot Sequencer

This block divides one turn of a rotating medium into sectors, and each sector into numbered time slots. Every sequencer is paced by its own reloadable 16-bit down-counter. All counters step on one shared tick enable, so changing the tick rate rescales every slot at once without touching any length setting. A state that waits on its counter loads the delay for the state it enters on the same clock as the transition. The wait therefore follows the move.

A revolution-level sequencer is started by the index pulse. It loads a revolution length that the user sets a little short, runs out its timer, and parks until the next index pulse re-locks it. An index pulse that arrives before the timer has run out forces the restart anyway and raises a one-cycle late flag.

A sector-level child sequencer starts whenever the parent accepts an index. It loads a sector length, also set a little short, and steps a slot number once per tick up to a programmable limit. When its timer expires it passes through one untimed closing state and then parks until a physical sector mark opens the next sector.

Top module: `rev_slot_sequencer`

## Requirements
- R1: Each counter is 16 bits wide and, when it is not being loaded, falls by exactly one on a cycle with `tick` high and holds on a cycle with `tick` low.
- R2: A counter that reads zero stays at zero when ticked; it never wraps.
- R3: A load takes priority over a tick in the same cycle, and the counter takes the full load value.
- R4: An `index_pulse` in any state moves `rev_state` to 1 (running) on the next edge, loads the revolution counter with `rev_len`, and raises `rev_strobe` for exactly that one cycle.
- R5: The same `index_pulse` restarts the sector sequencer: `sec_state` becomes 1 (slotting), `slot` and `sector` become 0, the sector counter loads `sec_len`, and `sec_strobe` is high for one cycle.
- R6: The timed states leave only when their counter reads zero, on the edge after it reads zero. `rev_state` 1 returns to 0 (waiting for index), and `sec_state` 1 moves to 2 (closing).
- R7: `sec_state` 2 is untimed and moves to 3 (waiting for a sector mark) on the next clock, whatever the counter and tick are doing.
- R8: In `sec_state` 1, `slot` rises by one on each tick while the counter is non-zero and `slot` is below its limit. The limit is `slots_per_sec` minus 1, or 15 when `slots_per_sec` is 0 or at least 16.
- R9: A `sector_mark` while `sec_state` is 1, 2 or 3 (and no index that cycle) adds one to `sector`, which wraps at 256. It also clears `slot`, moves to `sec_state` 1, reloads the counter with `sec_len`, and pulses `sec_strobe`. A mark in `sec_state` 0 has no effect.
- R10: `late_sync` is high for one cycle after an index pulse that arrived while `rev_state` was 1, and low after an index pulse taken in `rev_state` 0.
- R11: Synchronous reset clears both counters and all outputs. Both sequencers are left in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Shared tick enable for both counters |
| index_pulse | input | 1 | Once-per-revolution mark, one cycle |
| sector_mark | input | 1 | Physical sector boundary mark, one cycle |
| rev_len | input | 16 | Ticks loaded for one revolution |
| sec_len | input | 16 | Ticks loaded for one sector |
| slots_per_sec | input | 5 | Slots per sector, 1 to 16 (0 means 16) |
| slot | output | 4 | Current slot within the sector |
| sector | output | 8 | Sectors since the last index |
| rev_state | output | 1 | 0 waiting for index, 1 running |
| sec_state | output | 2 | 0 idle, 1 slotting, 2 closing, 3 waiting for mark |
| rev_strobe | output | 1 | One-cycle pulse on revolution start |
| sec_strobe | output | 1 | One-cycle pulse on sector start |
| late_sync | output | 1 | One-cycle flag for an index that arrived early |

## Verification
Assertions watch every cycle for the following:
- the counter rules: stepping only on tick, the floor at zero, and load priority;
- timed states holding while their counter is non-zero;
- the closing state chaining straight to the mark wait;
- marks being ignored while idle;
- the slot never moving backwards inside a sector;
- the late flag following an early index.

The bench alone can show the whole timeline across many cycles. That covers the exact edge on which each sequencer parks for a given length and tick pattern, and the slot value at which stepping saturates for each slot limit. It also covers the interplay of index and mark in the same cycle, and the wrap of the sector count. These are compared against a cycle model driven by random ticks, marks, index pulses and changing lengths.

// File: rtl/slotseq_pkg.sv
package slotseq_pkg;
    localparam int TMR_W  = 16;
    localparam int SLOT_W = 4;
    localparam int SPS_W  = SLOT_W + 1;
    localparam int SEC_W  = 8;

    typedef enum logic {
        REV_WAIT_IDX = 1'b0,
        REV_RUN      = 1'b1
    } rev_st_e;

    typedef enum logic [1:0] {
        SEC_IDLE      = 2'd0,
        SEC_SLOT      = 2'd1,
        SEC_CLOSE     = 2'd2,
        SEC_WAIT_MARK = 2'd3
    } sec_st_e;

    typedef struct packed {
        logic [SEC_W-1:0]  sector;
        logic [SLOT_W-1:0] slot;
    } slot_pos_t;

    // Highest slot index for a programmed slot count; 0 or oversize selects the full range.
    function automatic logic [SLOT_W-1:0] slot_limit(input logic [SPS_W-1:0] sps);
        if (sps == '0 || sps >= SPS_W'(2 ** SLOT_W))
            return '1;
        return SLOT_W'(sps - 1'b1);
    endfunction
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] count;

    // Load is evaluated ahead of the decrement, so a state's reload wins.
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick && count != '0)
            count <= count - 1'b1;
    end

    assign expired = (count == '0);

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));
    assert_tick_step_R1: assert property (@(posedge clk) disable iff (rst)
        (!load && tick && count != '0) |=> count == W'($past(count) - 1'b1));
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(count));
    assert_no_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && count == '0) |=> count == '0);
endmodule

// File: rtl/rev_seq.sv
module rev_seq
    import slotseq_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         index_pulse,
    input  logic [W-1:0] rev_len,
    output rev_st_e      state,
    output logic         rev_strobe,
    output logic         late_sync
);
    logic expired;

    seq_timer #(.W(W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (index_pulse),
        .load_val (rev_len),
        .expired  (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= REV_WAIT_IDX;
            rev_strobe <= 1'b0;
            late_sync  <= 1'b0;
        end else begin
            rev_strobe <= index_pulse;
            late_sync  <= index_pulse && (state == REV_RUN);
            if (index_pulse)
                state <= REV_RUN;
            else if (state == REV_RUN && expired)
                state <= REV_WAIT_IDX;
        end
    end

    assert_early_index_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (index_pulse && state == REV_RUN) |=> late_sync);
    assert_ontime_index_clean_R10: assert property (@(posedge clk) disable iff (rst)
        (index_pulse && state == REV_WAIT_IDX) |=> !late_sync);
    assert_run_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (state == REV_RUN && !expired && !index_pulse) |=> state == REV_RUN);
    assert_park_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (state == REV_WAIT_IDX && !index_pulse) |=> state == REV_WAIT_IDX);
    assert_strobe_on_start_R4: assert property (@(posedge clk) disable iff (rst)
        index_pulse |=> (rev_strobe && state == REV_RUN));
endmodule

// File: rtl/sec_seq.sv
module sec_seq
    import slotseq_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic             sector_mark,
    input  logic [W-1:0]     sec_len,
    input  logic [SPS_W-1:0] slots_per_sec,
    output sec_st_e          state,
    output slot_pos_t        pos,
    output logic             sec_strobe
);
    logic              expired;
    logic              restart;
    logic [SLOT_W-1:0] lim;

    assign restart = start || (sector_mark && state != SEC_IDLE);
    assign lim     = slot_limit(slots_per_sec);

    seq_timer #(.W(W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (restart),
        .load_val (sec_len),
        .expired  (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEC_IDLE;
            pos        <= '0;
            sec_strobe <= 1'b0;
        end else begin
            sec_strobe <= restart;
            if (restart) begin
                state    <= SEC_SLOT;
                pos.slot <= '0;
                pos.sector <= start ? '0 : pos.sector + 1'b1;
            end else begin
                unique case (state)
                    SEC_SLOT: begin
                        if (expired)
                            state <= SEC_CLOSE;
                        else if (tick && pos.slot < lim)
                            pos.slot <= pos.slot + 1'b1;
                    end
                    SEC_CLOSE: state <= SEC_WAIT_MARK;
                    default: ;
                endcase
            end
        end
    end

    assert_restart_clears_R5: assert property (@(posedge clk) disable iff (rst)
        start |=> (state == SEC_SLOT && pos == '0 && sec_strobe));
    assert_slot_timed_R6: assert property (@(posedge clk) disable iff (rst)
        (state == SEC_SLOT && !restart && !expired) |=> state == SEC_SLOT);
    assert_close_chains_R7: assert property (@(posedge clk) disable iff (rst)
        (state == SEC_CLOSE && !restart) |=> state == SEC_WAIT_MARK);
    assert_slot_rises_only_R8: assert property (@(posedge clk) disable iff (rst)
        (state == SEC_SLOT && !restart) |=> pos.slot >= $past(pos.slot));
    assert_idle_ignores_mark_R9: assert property (@(posedge clk) disable iff (rst)
        (state == SEC_IDLE && !start) |=> (state == SEC_IDLE && !sec_strobe));
endmodule

// File: rtl/rev_slot_sequencer.sv
module rev_slot_sequencer
    import slotseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              index_pulse,
    input  logic              sector_mark,
    input  logic [TMR_W-1:0]  rev_len,
    input  logic [TMR_W-1:0]  sec_len,
    input  logic [SPS_W-1:0]  slots_per_sec,
    output logic [SLOT_W-1:0] slot,
    output logic [SEC_W-1:0]  sector,
    output logic              rev_state,
    output logic [1:0]        sec_state,
    output logic              rev_strobe,
    output logic              sec_strobe,
    output logic              late_sync
);
    rev_st_e   rev_st;
    sec_st_e   sec_st;
    slot_pos_t pos;

    rev_seq #(.W(TMR_W)) u_rev (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .index_pulse (index_pulse),
        .rev_len     (rev_len),
        .state       (rev_st),
        .rev_strobe  (rev_strobe),
        .late_sync   (late_sync)
    );

    // The parent accepts every index, so its acceptance is the child's sync point.
    sec_seq #(.W(TMR_W)) u_sec (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .start         (index_pulse),
        .sector_mark   (sector_mark),
        .sec_len       (sec_len),
        .slots_per_sec (slots_per_sec),
        .state         (sec_st),
        .pos           (pos),
        .sec_strobe    (sec_strobe)
    );

    assign rev_state = rev_st;
    assign sec_state = sec_st;
    assign slot      = pos.slot;
    assign sector    = pos.sector;

    assert_reset_idle_R11: assert property (@(posedge clk)
        $past(rst) |-> (rev_state == 1'b0 && sec_state == 2'd0 && !rev_strobe && !sec_strobe));
endmodule

// File: tb/rev_slot_sequencer_tb.sv
`timescale 1ns/100ps
module rev_slot_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0, index_pulse = 1'b0, sector_mark = 1'b0;
    logic [15:0] rev_len = '0, sec_len = '0;
    logic [4:0]  slots_per_sec = 5'd4;
    logic [3:0]  slot;
    logic [7:0]  sector;
    logic        rev_state;
    logic [1:0]  sec_state;
    logic        rev_strobe, sec_strobe, late_sync;

    int total = 0, bad = 0;
    bit done = 0;
    int m_rs, m_rc, m_ss, m_sc, m_slot, m_sec, m_rstb, m_sstb, m_late;

    always #2.5 clk = ~clk;

    rev_slot_sequencer u_dut (
        .clk(clk), .rst(rst), .tick(tick), .index_pulse(index_pulse),
        .sector_mark(sector_mark), .rev_len(rev_len), .sec_len(sec_len),
        .slots_per_sec(slots_per_sec), .slot(slot), .sector(sector),
        .rev_state(rev_state), .sec_state(sec_state), .rev_strobe(rev_strobe),
        .sec_strobe(sec_strobe), .late_sync(late_sync)
    );

    function automatic int lim_of(int sp);
        return (sp == 0 || sp >= 16) ? 15 : sp - 1;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Cycle model built from the requirements, advanced once per rising edge.
    task automatic model_step();
        int rs, rc, ss, sc;
        bit idx, mk, tk, restart;
        if (rst) begin
            m_rs = 0; m_rc = 0; m_ss = 0; m_sc = 0; m_slot = 0; m_sec = 0;
            m_rstb = 0; m_sstb = 0; m_late = 0;
            return;
        end
        rs = m_rs; rc = m_rc; ss = m_ss; sc = m_sc;
        idx = index_pulse; mk = sector_mark; tk = tick;
        m_rstb = int'(idx);
        m_late = int'(idx && rs == 1);
        if (idx) begin
            m_rs = 1; m_rc = int'(rev_len);
        end else begin
            if (rs == 1 && rc == 0) m_rs = 0;
            if (tk && rc > 0) m_rc = rc - 1;
        end
        restart = idx || (mk && ss != 0);
        m_sstb = int'(restart);
        if (restart) begin
            m_ss = 1; m_slot = 0; m_sc = int'(sec_len);
            m_sec = idx ? 0 : (m_sec + 1) % 256;
        end else begin
            if (tk && sc > 0) m_sc = sc - 1;
            if (ss == 1) begin
                if (sc == 0) m_ss = 2;
                else if (tk && m_slot < lim_of(int'(slots_per_sec))) m_slot = m_slot + 1;
            end else if (ss == 2) begin
                m_ss = 3;
            end
        end
    endtask

    task automatic compare_all();
        check("R6 R1 R2 R3 rev_state", int'(rev_state), m_rs);
        check("R4 rev_strobe", int'(rev_strobe), m_rstb);
        check("R10 late_sync", int'(late_sync), m_late);
        check("R7 R6 sec_state", int'(sec_state), m_ss);
        check("R8 slot", int'(slot), m_slot);
        check("R9 R5 sector", int'(sector), m_sec);
        check("R5 sec_strobe", int'(sec_strobe), m_sstb);
    endtask

    task automatic cycle(bit tk, bit idx, bit mk);
        @(negedge clk);
        tick = tk; index_pulse = idx; sector_mark = mk;
        @(posedge clk);
        model_step();
        #1;
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        rst = 1'b1;
        repeat (3) cycle(1'b1, 1'b0, 1'b0);
        // R11: outputs cleared while reset is held.
        check("R11 reset rev_state", int'(rev_state), 0);
        check("R11 reset sec_state", int'(sec_state), 0);
        check("R11 reset slot/sector", int'({slot, sector}), 0);
        check("R11 reset strobes", int'({rev_strobe, sec_strobe, late_sync}), 0);
        @(negedge clk); rst = 1'b0;

        // R9: marks before any index leave the sector side idle.
        for (int i = 0; i < 20; i++) cycle(1'b1, 1'b0, (i % 3) == 0);
        check("R9 idle mark ignored sec_state", int'(sec_state), 0);
        check("R9 idle mark ignored sector", int'(sector), 0);

        // R4 R5 R6 R8: short revolution, three slots, ticks every cycle.
        rev_len = 16'd5; sec_len = 16'd6; slots_per_sec = 5'd3;
        cycle(1'b1, 1'b1, 1'b0);
        check("R4 strobe after index", int'(rev_strobe), 1);
        check("R5 sec start state", int'(sec_state), 1);
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, 1'b0);
        check("R8 slot saturates at limit", int'(slot), 2);
        check("R6 revolution still running at zero count", int'(rev_state), 1);
        cycle(1'b1, 1'b0, 1'b0);
        check("R6 revolution parks", int'(rev_state), 0);
        cycle(1'b1, 1'b0, 1'b0);
        check("R6 sector closes", int'(sec_state), 2);
        cycle(1'b0, 1'b0, 1'b0);
        check("R7 close chains to mark wait", int'(sec_state), 3);

        // R1: no ticks, counter holds, machine stays parked.
        rev_len = 16'd2;
        cycle(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) cycle(1'b0, 1'b0, 1'b0);
        check("R1 no tick keeps running", int'(rev_state), 1);

        // R10: early index while running.
        cycle(1'b0, 1'b1, 1'b0);
        check("R10 early index flagged", int'(late_sync), 1);
        cycle(1'b1, 1'b0, 1'b1);
        check("R10 flag lasts one cycle", int'(late_sync), 0);
        check("R9 mark advances sector", int'(sector), 1);

        // R8: slot count 0 means a full 16-slot range.
        slots_per_sec = 5'd0; sec_len = 16'd40;
        cycle(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 25; i++) cycle(1'b1, 1'b0, 1'b0);
        check("R8 zero count gives limit 15", int'(slot), 15);

        // Random phase: all outputs against the cycle model.
        for (int i = 0; i < 20000; i++) begin
            if ($urandom % 500 == 0) begin
                rev_len = 16'($urandom % 600);
                sec_len = 16'($urandom % 50);
                slots_per_sec = 5'($urandom % 21);
            end
            if (i == 9000) rev_len = 16'hFFFF;
            cycle(($urandom % 4) != 0, ($urandom % 400) == 0, ($urandom % 30) == 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule